// File: doc/BRIEF.md
# Two-Slot Transmit Endpoint Packet Buffer

This block sits between a processor and a USB packet engine on the device-to-host side of one endpoint. The processor loads a packet one byte per register write, then commits it by setting a ready flag. Up to two committed packets wait in arrival order. When the host asks for data, the engine issues a request and receives a one-cycle response that says whether a queued packet is available, how long it is, or whether an empty reply or a refusal should go out instead. The engine reads the oldest packet's bytes by index and pulses an acknowledge once the packet has been delivered, which frees that slot.

With two-slot operation enabled, committing into a buffer that still has a free slot leaves the ready flag reading low, so the processor can load the next packet at once. A presence flag tells software whether any packet is still pending. An optional automatic mode commits a packet by itself when a programmed byte count is reached. Committing with nothing loaded queues a packet of length zero. For an isochronous endpoint with nothing queued, a request is answered with a zero-length reply instead of a refusal.

Top module: `inep_dbl_buf`

## Requirements
- R1: After reset, pkt_rdy_o, pkt_present_o, irq_o and resp_valid_o are all 0.
- R2: Each accepted byte write appends one byte to the packet being loaded; once the packet is the oldest queued one, eng_rd_data_o at eng_rd_addr_i = k returns the k-th byte written (counting from 0).
- R3: With cfg_dbl_i = 1, a commit into an empty buffer leaves pkt_rdy_o at 0 in the next cycle; a second commit that fills both slots makes pkt_rdy_o read 1.
- R4: With cfg_dbl_i = 0, a commit makes pkt_rdy_o read 1 from the next cycle until the packet is acknowledged as sent.
- R5: pkt_present_o is 0 exactly when no committed packet is held; whenever pkt_present_o is 0, pkt_rdy_o is 0.
- R6: A commit never raises irq_o; an acknowledge (eng_sent_i) while a packet is queued raises irq_o for exactly the following cycle.
- R7: With cfg_autoset_i = 1 and cfg_maxpkt_i = N > 0, the write of the N-th byte commits the packet without cpu_set_ready_i; with N = 0 no automatic commit happens.
- R8: A commit with no bytes loaded queues a packet whose response has kind DATA (resp_kind_o = 2'b01) and resp_len_o = 0.
- R9: One cycle after eng_req_i, resp_valid_o is 1 for one cycle; resp_kind_o is DATA (2'b01) with resp_len_o equal to the oldest packet's length if one is queued, else ZLP (2'b10) with length 0 when cfg_iso_i = 1, else NAK (2'b00) with length 0.
- R10: Acknowledges release packets in commit order: after one acknowledge, the next request reports the second committed packet.
- R11: cpu_flush_i discards the oldest queued packet and raises irq_o the next cycle; with nothing queued it has no effect and raises no irq_o.
- R12: Byte writes and commits made while no slot is free (capacity 2 with cfg_dbl_i = 1, 1 otherwise) are ignored and do not alter the next loaded packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dbl_i | input | 1 | Two-slot operation enable |
| cfg_autoset_i | input | 1 | Automatic commit at byte threshold |
| cfg_iso_i | input | 1 | Endpoint is isochronous |
| cfg_maxpkt_i | input | 7 | Byte threshold for automatic commit (0 disables) |
| cpu_wr_valid_i | input | 1 | Byte write strobe |
| cpu_wr_data_i | input | 8 | Byte written |
| cpu_set_ready_i | input | 1 | Commit the loaded bytes as a packet |
| cpu_flush_i | input | 1 | Discard the oldest queued packet |
| pkt_rdy_o | output | 1 | Ready flag readback (1 = no free slot) |
| pkt_present_o | output | 1 | At least one packet queued |
| irq_o | output | 1 | Endpoint event pulse (sent or flushed) |
| eng_req_i | input | 1 | Host data request from packet engine |
| eng_sent_i | input | 1 | Oldest packet delivered |
| eng_rd_addr_i | input | 6 | Byte index into the oldest packet |
| eng_rd_data_o | output | 8 | Byte at eng_rd_addr_i |
| resp_valid_o | output | 1 | Response to a request is valid |
| resp_kind_o | output | 2 | 00 NAK, 01 DATA, 10 ZLP |
| resp_len_o | output | 7 | Length of the packet reported as DATA |

## Verification
The hardest state to reach is a full two-slot queue followed by further byte writes and commits that must vanish without trace, since their loss only shows up later in the length and content of a packet loaded afterwards. The stimulus fills both slots, pushes extra bytes and a commit, drains one slot, and then loads and requests a fresh packet whose reported length and bytes expose any leaked write. The same approach, in single-slot mode, covers the one-packet capacity, and the automatic-commit threshold is driven both at a nonzero count and at zero.

// File: rtl/inep_pkg.sv
package inep_pkg;
    localparam int NSLOT = 2;

    typedef enum logic [1:0] {
        RESP_NAK  = 2'b00,
        RESP_DATA = 2'b01,
        RESP_ZLP  = 2'b10
    } resp_kind_e;
endpackage

// File: rtl/inep_slot_store.sv
module inep_slot_store #(
    parameter int NSLOT = 2,
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_slot,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [NSLOT-1:0][DW-1:0] rd_word;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == SW'(s))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_word[s] = mem[rd_addr];
    end

    assign rd_data = rd_word[rd_slot];
endmodule

// File: rtl/inep_queue_ctrl.sv
module inep_queue_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl_i,
    input  logic          autoset_i,
    input  logic [CW-1:0] maxpkt_i,
    input  logic          wr_valid_i,
    input  logic          set_ready_i,
    input  logic          flush_i,
    input  logic          sent_i,
    output logic          wr_en_o,
    output logic          wr_slot_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          head_slot_o,
    output logic [CW-1:0] head_len_o,
    output logic          has_pkt_o,
    output logic          pkt_rdy_o,
    output logic          irq_o
);
    typedef struct packed {
        logic                head;
        logic [1:0]          count;
        logic [CW-1:0]       load_cnt;
        logic [1:0][CW-1:0]  len;
        logic                irq;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]    cap;
    logic          room;
    logic          wslot;
    logic          wr_ok;
    logic [CW-1:0] eff_len;
    logic          auto_hit;
    logic          commit;
    logic          pop;

    always_comb begin
        st_d     = st_q;
        cap      = dbl_i ? 2'd2 : 2'd1;
        room     = st_q.count < cap;
        wslot    = st_q.head ^ (st_q.count != 2'd0);
        wr_ok    = wr_valid_i && room && (st_q.load_cnt < CW'(DEPTH));
        eff_len  = st_q.load_cnt + CW'(wr_ok);
        auto_hit = autoset_i && (maxpkt_i != '0) && wr_ok && (eff_len == maxpkt_i);
        commit   = room && (set_ready_i || auto_hit);
        pop      = (sent_i || flush_i) && (st_q.count != 2'd0);

        if (commit) begin
            st_d.len[wslot] = eff_len;
            st_d.load_cnt   = '0;
        end else begin
            st_d.load_cnt   = eff_len;
        end

        st_d.count = st_q.count + {1'b0, commit} - {1'b0, pop};
        if (pop) begin
            st_d.head = ~st_q.head;
        end
        st_d.irq = pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o     = wr_ok;
    assign wr_slot_o   = wslot;
    assign wr_addr_o   = st_q.load_cnt[AW-1:0];
    assign head_slot_o = st_q.head;
    assign head_len_o  = st_q.len[st_q.head];
    assign has_pkt_o   = st_q.count != 2'd0;
    assign pkt_rdy_o   = st_q.count >= cap;
    assign irq_o       = st_q.irq;
endmodule

// File: rtl/inep_resp_gen.sv
module inep_resp_gen #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          iso_i,
    input  logic          has_pkt_i,
    input  logic [CW-1:0] head_len_i,
    output logic          resp_valid_o,
    output logic [1:0]    resp_kind_o,
    output logic [CW-1:0] resp_len_o
);
    import inep_pkg::*;

    typedef struct packed {
        logic          valid;
        resp_kind_e    kind;
        logic [CW-1:0] len;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_i;
        if (req_i) begin
            if (has_pkt_i) begin
                rsp_d.kind = RESP_DATA;
                rsp_d.len  = head_len_i;
            end else if (iso_i) begin
                rsp_d.kind = RESP_ZLP;
                rsp_d.len  = '0;
            end else begin
                rsp_d.kind = RESP_NAK;
                rsp_d.len  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, kind: RESP_NAK, len: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid_o = rsp_q.valid;
    assign resp_kind_o  = rsp_q.kind;
    assign resp_len_o   = rsp_q.len;
endmodule

// File: rtl/inep_dbl_buf.sv
module inep_dbl_buf #(
    parameter int DATA_W     = 8,
    parameter int SLOT_BYTES = 64,
    localparam int AW        = $clog2(SLOT_BYTES),
    localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dbl_i,
    input  logic              cfg_autoset_i,
    input  logic              cfg_iso_i,
    input  logic [CW-1:0]     cfg_maxpkt_i,
    input  logic              cpu_wr_valid_i,
    input  logic [DATA_W-1:0] cpu_wr_data_i,
    input  logic              cpu_set_ready_i,
    input  logic              cpu_flush_i,
    output logic              pkt_rdy_o,
    output logic              pkt_present_o,
    output logic              irq_o,
    input  logic              eng_req_i,
    input  logic              eng_sent_i,
    input  logic [AW-1:0]     eng_rd_addr_i,
    output logic [DATA_W-1:0] eng_rd_data_o,
    output logic              resp_valid_o,
    output logic [1:0]        resp_kind_o,
    output logic [CW-1:0]     resp_len_o
);
    logic          wr_en;
    logic          wr_slot;
    logic [AW-1:0] wr_addr;
    logic          head_slot;
    logic [CW-1:0] head_len;
    logic          has_pkt;

    inep_queue_ctrl #(.DEPTH(SLOT_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbl_i       (cfg_dbl_i),
        .autoset_i   (cfg_autoset_i),
        .maxpkt_i    (cfg_maxpkt_i),
        .wr_valid_i  (cpu_wr_valid_i),
        .set_ready_i (cpu_set_ready_i),
        .flush_i     (cpu_flush_i),
        .sent_i      (eng_sent_i),
        .wr_en_o     (wr_en),
        .wr_slot_o   (wr_slot),
        .wr_addr_o   (wr_addr),
        .head_slot_o (head_slot),
        .head_len_o  (head_len),
        .has_pkt_o   (has_pkt),
        .pkt_rdy_o   (pkt_rdy_o),
        .irq_o       (irq_o)
    );

    inep_slot_store #(
        .NSLOT (inep_pkg::NSLOT),
        .DEPTH (SLOT_BYTES),
        .DW    (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_addr (wr_addr),
        .wr_data (cpu_wr_data_i),
        .rd_slot (head_slot),
        .rd_addr (eng_rd_addr_i),
        .rd_data (eng_rd_data_o)
    );

    inep_resp_gen #(.CW(CW)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (eng_req_i),
        .iso_i        (cfg_iso_i),
        .has_pkt_i    (has_pkt),
        .head_len_i   (head_len),
        .resp_valid_o (resp_valid_o),
        .resp_kind_o  (resp_kind_o),
        .resp_len_o   (resp_len_o)
    );

    assign pkt_present_o = has_pkt;
endmodule

// File: rtl/inep_dbl_buf_chk.sv
module inep_dbl_buf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_dbl_i,
    input logic       cfg_iso_i,
    input logic       cpu_set_ready_i,
    input logic       cpu_flush_i,
    input logic       pkt_rdy_o,
    input logic       pkt_present_o,
    input logic       irq_o,
    input logic       eng_req_i,
    input logic       eng_sent_i,
    input logic       resp_valid_o,
    input logic [1:0] resp_kind_o
);
    assert_rdy_needs_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_present_o |-> !pkt_rdy_o);

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(eng_sent_i || cpu_flush_i));

    assert_no_irq_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_present_o |=> !irq_o);

    assert_resp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> $past(eng_req_i));

    assert_zlp_only_iso_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_kind_o == 2'b10) |-> $past(cfg_iso_i));

    assert_dbl_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dbl_i && !pkt_present_o && cpu_set_ready_i)
        |=> (pkt_present_o && (!cfg_dbl_i || !pkt_rdy_o)));

    assert_single_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dbl_i && !pkt_present_o && cpu_set_ready_i)
        |=> (cfg_dbl_i || pkt_rdy_o));
endmodule

bind inep_dbl_buf inep_dbl_buf_chk u_chk (.*);

// File: tb/inep_dbl_buf_tb.sv
`timescale 1ns/1ps
module inep_dbl_buf_tb;
    localparam int DW = 8;
    localparam int SB = 64;
    localparam int AW = $clog2(SB);
    localparam int CW = $clog2(SB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_dbl = 1'b0, cfg_autoset = 1'b0, cfg_iso = 1'b0;
    logic [CW-1:0] cfg_maxpkt = '0;
    logic          wr_valid = 1'b0, set_ready = 1'b0, flush = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          pkt_rdy, pkt_present, irq;
    logic          eng_req = 1'b0, eng_sent = 1'b0;
    logic [AW-1:0] eng_rd_addr = '0;
    logic [DW-1:0] eng_rd_data;
    logic          resp_valid;
    logic [1:0]    resp_kind;
    logic [CW-1:0] resp_len;

    always #2 clk = ~clk;

    inep_dbl_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dbl_i(cfg_dbl), .cfg_autoset_i(cfg_autoset), .cfg_iso_i(cfg_iso),
        .cfg_maxpkt_i(cfg_maxpkt),
        .cpu_wr_valid_i(wr_valid), .cpu_wr_data_i(wr_data),
        .cpu_set_ready_i(set_ready), .cpu_flush_i(flush),
        .pkt_rdy_o(pkt_rdy), .pkt_present_o(pkt_present), .irq_o(irq),
        .eng_req_i(eng_req), .eng_sent_i(eng_sent),
        .eng_rd_addr_i(eng_rd_addr), .eng_rd_data_o(eng_rd_data),
        .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_len_o(resp_len)
    );

    typedef struct {
        int          len;
        logic [7:0]  b [SB];
    } pkt_t;

    typedef struct {
        int   kind;
        pkt_t pkt;
        string tag;
    } exp_t;

    pkt_t mq[$];
    pkt_t cur;
    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cap();
        return cfg_dbl ? 2 : 1;
    endfunction

    function automatic void model_commit();
        if (mq.size() < cap()) begin
            mq.push_back(cur);
            cur.len = 0;
        end
    endfunction

    task automatic wr(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        if (mq.size() < cap() && cur.len < SB) begin
            cur.b[cur.len] = d;
            cur.len++;
            if (cfg_autoset && cfg_maxpkt != 0 && cur.len == int'(cfg_maxpkt)) model_commit();
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic commit(input string tag);
        set_ready = 1'b1;
        model_commit();
        @(negedge clk);
        set_ready = 1'b0;
        chk({tag, " commit irq"}, int'(irq), 0);
    endtask

    task automatic release_pkt(input bit use_flush, input string tag);
        int exp_irq;
        exp_irq = (mq.size() != 0) ? 1 : 0;
        if (use_flush) flush = 1'b1; else eng_sent = 1'b1;
        if (mq.size() != 0) void'(mq.pop_front());
        @(negedge clk);
        flush = 1'b0; eng_sent = 1'b0;
        chk({tag, " irq"}, int'(irq), exp_irq);
        @(negedge clk);
        chk({tag, " irq one cycle"}, int'(irq), 0);
    endtask

    task automatic request(input string tag);
        exp_t e;
        e.tag = tag;
        e.pkt.len = 0;
        if (mq.size() != 0) begin e.kind = 1; e.pkt = mq[0]; end
        else if (cfg_iso)   e.kind = 2;
        else                e.kind = 0;
        sb.push_back(e);
        eng_req = 1'b1;
        @(negedge clk);
        eng_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic status(input string tag);
        chk({tag, " rdy"}, int'(pkt_rdy), (mq.size() >= cap()) ? 1 : 0);
        chk({tag, " present"}, int'(pkt_present), (mq.size() != 0) ? 1 : 0);
    endtask

    // monitor: pops expectations when a response appears
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " kind"}, int'(resp_kind), e.kind);
                chk({e.tag, " len"}, int'(resp_len), (e.kind == 1) ? e.pkt.len : 0);
                if (e.kind == 1) begin
                    for (int i = 0; i < e.pkt.len; i++) begin
                        eng_rd_addr = AW'(i);
                        #0.01;
                        chk({e.tag, " R2 byte"}, int'(eng_rd_data), int'(e.pkt.b[i]));
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur.len = 0;
        repeat (3) @(negedge clk);
        chk("R1 rdy", int'(pkt_rdy), 0);
        chk("R1 present", int'(pkt_present), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 resp_valid", int'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        status("R1 after release");

        // empty requests
        request("R9 nak");
        cfg_iso = 1'b1;
        request("R9 zlp iso");
        cfg_iso = 1'b0;

        // two-slot queueing, overflow drop, FIFO order
        cfg_dbl = 1'b1;
        wr(8'hA1); wr(8'hA2); wr(8'hA3);
        commit("R3 first");
        status("R3 free slot");
        wr(8'hB1); wr(8'hB2);
        commit("R3 second");
        status("R3 full");
        wr(8'hEE); wr(8'hEF);
        commit("R12 commit when full");
        status("R12 full stays");
        request("R10 oldest first");
        release_pkt(1'b0, "R6 sent");
        status("R5 one left");
        request("R10 second packet");
        release_pkt(1'b0, "R6 sent second");
        status("R5 empty");
        wr(8'h31); wr(8'h32);
        commit("R12 fresh");
        request("R12 no leaked bytes");
        release_pkt(1'b0, "R6 sent fresh");

        // zero-length packet
        commit("R8 zero length");
        status("R8 queued");
        cfg_iso = 1'b1;
        request("R8 data len0");
        cfg_iso = 1'b0;
        release_pkt(1'b0, "R8 sent");

        // single-slot mode
        cfg_dbl = 1'b0;
        wr(8'h51);
        commit("R4 single");
        status("R4 ready high");
        wr(8'h99);
        commit("R12 single full");
        status("R4 still ready");
        release_pkt(1'b0, "R4 sent");
        status("R4 cleared");
        wr(8'h61); wr(8'h62);
        commit("R12 single fresh");
        request("R12 single no leak");
        release_pkt(1'b0, "R4 sent again");

        // automatic commit
        cfg_dbl = 1'b1; cfg_autoset = 1'b1; cfg_maxpkt = CW'(4);
        for (int i = 0; i < 4; i++) wr(8'h70 + 8'(i));
        status("R7 auto first");
        for (int i = 0; i < 4; i++) wr(8'h80 + 8'(i));
        status("R7 auto second");
        request("R7 auto len");
        release_pkt(1'b0, "R7 sent a");
        release_pkt(1'b0, "R7 sent b");
        cfg_maxpkt = '0;
        for (int i = 0; i < 5; i++) wr(8'h90 + 8'(i));
        status("R7 zero threshold no commit");
        commit("R7 manual");
        request("R7 manual len");
        release_pkt(1'b0, "R7 sent c");
        cfg_autoset = 1'b0;

        // flush
        wr(8'hC1);
        commit("R11 p1");
        wr(8'hD1); wr(8'hD2); wr(8'hD3);
        commit("R11 p2");
        release_pkt(1'b1, "R11 flush");
        status("R11 after flush");
        request("R11 second survives");
        release_pkt(1'b0, "R11 sent");
        release_pkt(1'b1, "R11 flush empty");
        status("R11 empty");

        repeat (3) @(negedge clk);
        chk("R9 all responses seen", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule